// File: doc/BRIEF.md
# Dual-Car Two-Landing Lift Controller

This block supervises two lift cars that shuttle between a lower landing and an upper landing. It reads two landing call buttons (an up call at the lower landing, a down call at the upper landing), an up and a down button inside each car, a pair of landing-presence sensors per car and a door-obstruction sensor per car. For each car it drives three levels: travel up, travel down and door open.

Each landing call is latched and lit until it is served. A dispatcher gives the call to exactly one car. A car already travelling toward the calling landing takes the call with no further command. Otherwise a car parked at that landing opens its door, and failing that, a parked car at the other landing is sent. Between two equally placed parked cars, the lower-numbered car wins. The door time is counted in ticks from a free-running prescaler. An obstruction holds the door open and restarts its count. Buttons that make no sense for a car's situation are dropped.

All pins are plain level controls sampled on the rising clock edge. There is no streaming data path, so no valid/ready handshake and no back-pressure. A button may be held for any number of cycles. Each sampled cycle counts as a press.

Top module: `elev_duo_ctrl`

## Requirements
- R1: After reset every travel, door and lamp output is 0, and each car is taken to be parked at the lower landing with its door closed.
- R2: A car parked with its door closed starts travelling on the edge that samples an in-car button for the other landing (cab up selects the upper landing, cab down the lower). A car never shows more than one of travel up, travel down and door open at once.
- R3: A car travelling up stops and opens its door on the edge that samples its upper-landing sensor. A car travelling down does the same on its lower-landing sensor.
- R4: An opened door stays open for DOOR_TICKS prescaler ticks, one tick every TICK_DIV cycles, and then closes.
- R5: While a car's obstruction sensor is high its door stays open. The door count restarts on every cycle the sensor is high.
- R6: An in-car button for the landing the car is parked at opens the door, or keeps it open and restarts its count, with no travel.
- R7: While a car is travelling, both of its in-car buttons are ignored: the car keeps moving until its destination sensor, and afterwards it does not set off again on their account.
- R8: A landing call lamp turns on the edge after its button is sampled. It turns off on the edge after the assigned car shows an open door at that landing.
- R9: A car already travelling toward the calling landing is given the call, and the other car is not moved or opened.
- R10: With no car travelling toward the calling landing, a car parked at that landing is chosen ahead of a car at the other landing, and its door opens on the second edge after the press.
- R11: When both cars are parked at the same landing, car 0 is chosen. A call from the other landing therefore starts car 0 travelling on the second edge after the press, while car 1 stays put.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_f1_up_i | input | 1 | Up call button at the lower landing |
| call_f2_dn_i | input | 1 | Down call button at the upper landing |
| cab_up_i | input | N_CARS | In-car button for the upper landing, one bit per car |
| cab_dn_i | input | N_CARS | In-car button for the lower landing, one bit per car |
| at_lo_i | input | N_CARS | Car is level with the lower landing |
| at_hi_i | input | N_CARS | Car is level with the upper landing |
| obstruct_i | input | N_CARS | Door path blocked |
| mv_up_o | output | N_CARS | Drive car upward |
| mv_dn_o | output | N_CARS | Drive car downward |
| door_o | output | N_CARS | Hold car door open |
| lamp_f1_up_o | output | 1 | Lower-landing up call pending |
| lamp_f2_dn_o | output | 1 | Upper-landing down call pending |

## Verification
A car's remembered landing is never shown directly. If that register is wrong, a button for the car's own landing sends it travelling when its door should open, and the wrong drive pin rises on the very next edge. A lost or stuck owner in a landing slot shows up as a lamp that never clears, or as the second car moving or opening two edges after the press. A door count loaded with the wrong value or not restarted by obstruction moves the falling edge of the door output. The bench therefore samples the door both inside and beyond the legal window.

// File: rtl/elev_pkg.sv
package elev_pkg;
  typedef enum logic [1:0] {
    CAR_IDLE = 2'd0,
    CAR_DOOR = 2'd1,
    CAR_UP   = 2'd2,
    CAR_DN   = 2'd3
  } car_st_e;
endpackage

// File: rtl/elev_tick.sv
module elev_tick #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick_o = (cnt == LAST);
endmodule

// File: rtl/elev_car.sv
module elev_car
  import elev_pkg::*;
#(
  parameter int unsigned DOOR_TICKS = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    want_lo_i,
  input  logic    want_hi_i,
  input  logic    at_lo_i,
  input  logic    at_hi_i,
  input  logic    obstruct_i,
  output car_st_e st_o,
  output logic    flr_o,
  output logic    mv_up_o,
  output logic    mv_dn_o,
  output logic    door_o
);
  localparam int unsigned TW = $clog2(DOOR_TICKS + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(DOOR_TICKS);

  car_st_e       st, st_n;
  logic          flr, flr_n;     // 0 = lower landing, 1 = upper
  logic          pend, pend_n;   // trip to the other landing owed
  logic [TW-1:0] tmr;

  logic parked, want_here, want_away, arrive, go, tmr_load;

  always_comb begin
    parked    = (st == CAR_IDLE) || (st == CAR_DOOR);
    want_here = flr ? want_hi_i : want_lo_i;
    want_away = flr ? want_lo_i : want_hi_i;
    arrive    = ((st == CAR_UP) && at_hi_i) || ((st == CAR_DN) && at_lo_i);
    go        = (st == CAR_IDLE) && !want_here && (pend || want_away);
    tmr_load  = arrive || (parked && want_here) ||
                ((st == CAR_DOOR) && obstruct_i);
  end

  always_comb begin
    st_n   = st;
    flr_n  = flr;
    pend_n = (pend || (parked && want_away)) && !go;
    unique case (st)
      CAR_IDLE: begin
        if (want_here)  st_n = CAR_DOOR;
        else if (go)    st_n = flr ? CAR_DN : CAR_UP;
      end
      CAR_DOOR: begin
        if ((tmr == '0) && !obstruct_i && !want_here) st_n = CAR_IDLE;
      end
      CAR_UP: begin
        if (at_hi_i) begin
          st_n  = CAR_DOOR;
          flr_n = 1'b1;
        end
      end
      CAR_DN: begin
        if (at_lo_i) begin
          st_n  = CAR_DOOR;
          flr_n = 1'b0;
        end
      end
      default: st_n = CAR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= CAR_IDLE;
      flr  <= 1'b0;
      pend <= 1'b0;
      tmr  <= '0;
    end else begin
      st   <= st_n;
      flr  <= flr_n;
      pend <= pend_n;
      if (tmr_load)                  tmr <= T_LOAD;
      else if (tick_i && tmr != '0)  tmr <= tmr - 1'b1;
    end
  end

  assign st_o    = st;
  assign flr_o   = flr;
  assign mv_up_o = (st == CAR_UP);
  assign mv_dn_o = (st == CAR_DN);
  assign door_o  = (st == CAR_DOOR);
endmodule

// File: rtl/elev_hall_slot.sv
module elev_hall_slot
  import elev_pkg::*;
#(
  parameter int unsigned N   = 2,
  parameter bit          FLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         press_i,
  input  car_st_e      st_i [N],
  input  logic [N-1:0] flr_i,
  output logic [N-1:0] want_o,
  output logic         lamp_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic          pend, own_v;
  logic [IW-1:0] own_idx;
  logic [N-1:0]  heading, park_here, park_far;
  logic          pick_v, pick_req;
  logic [IW-1:0] pick_idx;
  logic          assign_now, served;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      heading[i]   = FLR ? (st_i[i] == CAR_UP) : (st_i[i] == CAR_DN);
      park_here[i] = ((st_i[i] == CAR_IDLE) || (st_i[i] == CAR_DOOR)) &&
                     (flr_i[i] == FLR);
      park_far[i]  = ((st_i[i] == CAR_IDLE) || (st_i[i] == CAR_DOOR)) &&
                     (flr_i[i] != FLR);
    end
  end

  // Later loops override earlier ones; descending index gives car 0 priority.
  always_comb begin
    pick_v   = 1'b0;
    pick_req = 1'b0;
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (park_far[i]) begin
        pick_v = 1'b1; pick_req = 1'b1; pick_idx = IW'(i);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (park_here[i]) begin
        pick_v = 1'b1; pick_req = 1'b1; pick_idx = IW'(i);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (heading[i]) begin
        pick_v = 1'b1; pick_req = 1'b0; pick_idx = IW'(i);
      end
    end
  end

  always_comb begin
    assign_now = pend && !own_v && pick_v;
    served     = own_v && (st_i[own_idx] == CAR_DOOR) && (flr_i[own_idx] == FLR);
    for (int i = 0; i < N; i++) begin
      want_o[i] = assign_now && pick_req && (pick_idx == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      own_v   <= 1'b0;
      own_idx <= '0;
    end else begin
      pend <= (pend && !served) || press_i;
      if (served) begin
        own_v <= 1'b0;
      end else if (assign_now) begin
        own_v   <= 1'b1;
        own_idx <= pick_idx;
      end
    end
  end

  assign lamp_o = pend;
endmodule

// File: rtl/elev_duo_ctrl.sv
module elev_duo_ctrl
  import elev_pkg::*;
#(
  parameter int unsigned N_CARS     = 2,
  parameter int unsigned TICK_DIV   = 50_000_000,
  parameter int unsigned DOOR_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_f1_up_i,
  input  logic              call_f2_dn_i,
  input  logic [N_CARS-1:0] cab_up_i,
  input  logic [N_CARS-1:0] cab_dn_i,
  input  logic [N_CARS-1:0] at_lo_i,
  input  logic [N_CARS-1:0] at_hi_i,
  input  logic [N_CARS-1:0] obstruct_i,
  output logic [N_CARS-1:0] mv_up_o,
  output logic [N_CARS-1:0] mv_dn_o,
  output logic [N_CARS-1:0] door_o,
  output logic              lamp_f1_up_o,
  output logic              lamp_f2_dn_o
);
  localparam int unsigned N_LAND = 2;

  logic              tick;
  car_st_e           car_st [N_CARS];
  logic [N_CARS-1:0] car_flr;
  logic [N_CARS-1:0] slot_want [N_LAND];
  logic              slot_press [N_LAND];
  logic              slot_lamp  [N_LAND];

  elev_tick #(.DIV(TICK_DIV)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  assign slot_press[0] = call_f1_up_i;
  assign slot_press[1] = call_f2_dn_i;
  assign lamp_f1_up_o  = slot_lamp[0];
  assign lamp_f2_dn_o  = slot_lamp[1];

  for (genvar f = 0; f < N_LAND; f++) begin : g_land
    elev_hall_slot #(.N(N_CARS), .FLR(f == 1)) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .press_i (slot_press[f]),
      .st_i    (car_st),
      .flr_i   (car_flr),
      .want_o  (slot_want[f]),
      .lamp_o  (slot_lamp[f])
    );
  end

  for (genvar c = 0; c < N_CARS; c++) begin : g_car
    elev_car #(.DOOR_TICKS(DOOR_TICKS)) car_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .want_lo_i  (cab_dn_i[c] | slot_want[0][c]),
      .want_hi_i  (cab_up_i[c] | slot_want[1][c]),
      .at_lo_i    (at_lo_i[c]),
      .at_hi_i    (at_hi_i[c]),
      .obstruct_i (obstruct_i[c]),
      .st_o       (car_st[c]),
      .flr_o      (car_flr[c]),
      .mv_up_o    (mv_up_o[c]),
      .mv_dn_o    (mv_dn_o[c]),
      .door_o     (door_o[c])
    );
  end
endmodule

// File: rtl/elev_duo_chk.sv
module elev_duo_chk #(
  parameter int unsigned N_CARS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_f1_up_i,
  input logic              call_f2_dn_i,
  input logic [N_CARS-1:0] at_lo_i,
  input logic [N_CARS-1:0] at_hi_i,
  input logic [N_CARS-1:0] obstruct_i,
  input logic [N_CARS-1:0] mv_up_o,
  input logic [N_CARS-1:0] mv_dn_o,
  input logic [N_CARS-1:0] door_o,
  input logic              lamp_f1_up_o,
  input logic              lamp_f2_dn_o
);
  for (genvar i = 0; i < N_CARS; i++) begin : g_c
    p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mv_up_o[i], mv_dn_o[i], door_o[i]}));

    p_up_arrive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mv_up_o[i] && at_hi_i[i] |=> door_o[i] && !mv_up_o[i]);

    p_dn_arrive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mv_dn_o[i] && at_lo_i[i] |=> door_o[i] && !mv_dn_o[i]);

    p_obstruct_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      door_o[i] && obstruct_i[i] |=> door_o[i]);

    p_up_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mv_up_o[i] && !at_hi_i[i] |=> mv_up_o[i]);

    p_dn_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mv_dn_o[i] && !at_lo_i[i] |=> mv_dn_o[i]);
  end

  p_lamp_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    call_f1_up_i |=> lamp_f1_up_o);

  p_lamp_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    call_f2_dn_i |=> lamp_f2_dn_o);
endmodule

bind elev_duo_ctrl elev_duo_chk #(.N_CARS(N_CARS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .call_f1_up_i (call_f1_up_i),
  .call_f2_dn_i (call_f2_dn_i),
  .at_lo_i      (at_lo_i),
  .at_hi_i      (at_hi_i),
  .obstruct_i   (obstruct_i),
  .mv_up_o      (mv_up_o),
  .mv_dn_o      (mv_dn_o),
  .door_o       (door_o),
  .lamp_f1_up_o (lamp_f1_up_o),
  .lamp_f2_dn_o (lamp_f2_dn_o)
);

// File: tb/elev_duo_ctrl_tb_top.sv
module elev_duo_ctrl_tb_top;
  localparam int unsigned NC = 2;
  // observation vector bit positions
  localparam int B_UP0 = 0, B_UP1 = 1, B_DN0 = 2, B_DN1 = 3;
  localparam int B_DR0 = 4, B_DR1 = 5, B_L1 = 6, B_L2 = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_f1 = 1'b0, call_f2 = 1'b0;
  logic [NC-1:0] cab_up = '0, cab_dn = '0, at_lo = 2'b11, at_hi = '0, obst = '0;
  logic [NC-1:0] mv_up, mv_dn, door;
  logic lamp1, lamp2;

  always #2 clk = ~clk;

  elev_duo_ctrl #(.N_CARS(NC), .TICK_DIV(2), .DOOR_TICKS(4)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .call_f1_up_i (call_f1), .call_f2_dn_i (call_f2),
    .cab_up_i (cab_up), .cab_dn_i (cab_dn),
    .at_lo_i (at_lo), .at_hi_i (at_hi), .obstruct_i (obst),
    .mv_up_o (mv_up), .mv_dn_o (mv_dn), .door_o (door),
    .lamp_f1_up_o (lamp1), .lamp_f2_dn_o (lamp2)
  );

  logic [7:0] obs;
  assign obs = {lamp2, lamp1, door[1], door[0], mv_dn[1], mv_dn[0], mv_up[1], mv_up[0]};

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_obs(input string tag, input logic [7:0] mask, input logic [7:0] val);
    exp_q.push_back({mask, val});
    tag_q.push_back(tag);
  endtask

  function automatic logic [7:0] bm(input int b);
    return 8'(1) << b;
  endfunction

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ((obs & e[15:8]) !== (e[7:0] & e[15:8])) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b (mask %b)", t, obs & e[15:8],
                   e[7:0] & e[15:8], e[15:8]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [7:0] CAR0 = 8'b0001_0101;
  localparam logic [7:0] CAR1 = 8'b0010_1010;

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_obs("R1 reset outputs", 8'hFF, 8'h00);
    step(2);
    expect_obs("R1 idle after reset", 8'hFF, 8'h00);

    // car 0 up from lower landing
    cab_up[0] = 1'b1; step(1); cab_up[0] = 1'b0; at_lo[0] = 1'b0;
    expect_obs("R2 car0 starts up", CAR0, bm(B_UP0));
    cab_dn[0] = 1'b1; step(1); cab_dn[0] = 1'b0; step(3);
    expect_obs("R7 floor-1 button ignored in travel", CAR0, bm(B_UP0));
    at_hi[0] = 1'b1; step(1);
    expect_obs("R3 arrival opens door", CAR0, bm(B_DR0));
    step(5);
    expect_obs("R4 door still open", CAR0, bm(B_DR0));
    step(8);
    expect_obs("R4 door closed, R7 no leftover trip", CAR0, 8'h00);

    // cab up while already upstairs
    cab_up[0] = 1'b1; step(1); cab_up[0] = 1'b0;
    expect_obs("R6 up at upper landing opens door", CAR0, bm(B_DR0));
    step(12);
    expect_obs("R6 no travel afterwards", CAR0, 8'h00);

    // obstruction
    cab_up[0] = 1'b1; step(1); cab_up[0] = 1'b0; obst[0] = 1'b1;
    step(20);
    expect_obs("R5 door held by obstruction", CAR0, bm(B_DR0));
    obst[0] = 1'b0; step(5);
    expect_obs("R5 count restarted", CAR0, bm(B_DR0));
    step(8);
    expect_obs("R5 door closes after release", CAR0, 8'h00);

    // car0 upstairs, car1 downstairs: down call upstairs
    call_f2 = 1'b1; step(1); call_f2 = 1'b0;
    expect_obs("R8 down lamp on", bm(B_L2), bm(B_L2));
    step(1);
    expect_obs("R10 car at calling landing opens", CAR0 | CAR1, bm(B_DR0));
    step(1);
    expect_obs("R8 down lamp cleared", bm(B_L2), 8'h00);
    step(12);

    // up call downstairs: car1 is there
    call_f1 = 1'b1; step(1); call_f1 = 1'b0;
    expect_obs("R8 up lamp on", bm(B_L1), bm(B_L1));
    step(1);
    expect_obs("R10 car1 opens at lower landing", CAR0 | CAR1, bm(B_DR1));
    step(1);
    expect_obs("R8 up lamp cleared", bm(B_L1), 8'h00);
    step(12);

    // move car1 up so both are upstairs
    cab_up[1] = 1'b1; step(1); cab_up[1] = 1'b0; at_lo[1] = 1'b0;
    expect_obs("R2 car1 starts up", CAR1, bm(B_UP1));
    at_hi[1] = 1'b1; step(1);
    expect_obs("R3 car1 arrives", CAR1, bm(B_DR1));
    step(12);

    // car0 heading down, then up call downstairs
    cab_dn[0] = 1'b1; step(1); cab_dn[0] = 1'b0; at_hi[0] = 1'b0;
    expect_obs("R2 car0 starts down", CAR0, bm(B_DN0));
    call_f1 = 1'b1; step(1); call_f1 = 1'b0; step(3);
    expect_obs("R9 heading car keeps call, car1 stays", CAR0 | CAR1 | bm(B_L1),
               bm(B_DN0) | bm(B_L1));
    at_lo[0] = 1'b1; step(1);
    expect_obs("R3 car0 arrives downstairs", CAR0 | CAR1, bm(B_DR0));
    step(1);
    expect_obs("R9 call cleared by heading car", bm(B_L1), 8'h00);
    step(12);

    // bring car1 down: both at lower landing
    cab_dn[1] = 1'b1; step(1); cab_dn[1] = 1'b0; at_hi[1] = 1'b0;
    expect_obs("R2 car1 starts down", CAR1, bm(B_DN1));
    at_lo[1] = 1'b1; step(1);
    expect_obs("R3 car1 arrives downstairs", CAR1, bm(B_DR1));
    step(12);

    // both parked downstairs: down call upstairs goes to car0
    call_f2 = 1'b1; step(1); call_f2 = 1'b0;
    expect_obs("R8 down lamp on again", bm(B_L2), bm(B_L2));
    step(1);
    expect_obs("R11 car0 preferred", CAR0 | CAR1, bm(B_UP0));
    at_lo[0] = 1'b0; at_hi[0] = 1'b1; step(1);
    expect_obs("R11 car0 opens upstairs", CAR0 | CAR1, bm(B_DR0));
    step(1);
    expect_obs("R8 down lamp cleared by car0", bm(B_L2), 8'h00);
    step(12);
    expect_obs("R4 all quiet", 8'hFF, 8'h00);

    step(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule